// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block joins two eight-line interrupt controllers, a primary and a secondary, into one unit with sixteen request inputs. Whenever the secondary holds a request that it would deliver, that condition is latched as an edge on request line 2 of the primary. Line 2 of the primary is the cascade line. The external input that maps onto it is not used. The primary's deliverable request drives the interrupt output to the processor. A one-cycle wake pulse marks each rise of that output.

The processor answers with a one-cycle acknowledge strobe, and the block returns an 8-bit vector in the next cycle. If the primary has nothing to deliver, the vector is the primary spurious code. If the primary's winner is the cascade line, the secondary's winner is acknowledged and the secondary base supplies the vector. If at that point the secondary has nothing to deliver, the vector is the secondary spurious code. Any other winner gives the primary base plus its line number.

Software reaches the two controllers and their trigger-mode registers through a byte-wide I/O port bus. Through this bus it can mask lines, retire in-service lines and select which register is read back.

Top module: `cascade_ack_seq`

## Requirements
- R1: After reset the interrupt output, the wake pulse, the vector and the read data are 0. The mask, pending, in-service and trigger-mode registers of both controllers are clear, and a read of the even port returns the pending register.
- R2: In each controller the lowest-numbered line that is pending and unmasked wins. It is delivered only if its number is below every line in service, so a request with a lower priority waits until its predecessor is retired. Writing a mask bit (odd port, bit n = line n) withholds line n while leaving it pending.
- R3: A deliverable request in the secondary sets pending bit 2 of the primary as an edge-latched request, and acknowledging the cascade clears that bit. The external line 2 never raises a request.
- R4: An acknowledge whose primary winner is line 2 sets bit 2 in service in the primary. It also sets the secondary winner in service and returns SEC_BASE + that line. Lines 8 to 15 are secondary lines 0 to 7.
- R5: An acknowledge with no primary winner returns PRI_BASE + 7 and changes no state.
- R6: An acknowledge whose primary winner is line 2 while the secondary has no winner returns SEC_BASE + 7. In that case the secondary's in-service register stays unchanged.
- R7: Bit n of a trigger-mode register selects level (1) or edge (0) for line n. Only bits F8h (primary) and DEh (secondary) can be written. An edge request is latched on a rise of its line and cleared by its acknowledge. A level request follows its line and is not cleared by acknowledge.
- R8: Even-port command writes act as follows. A value of 001xxxxx clears the lowest-numbered in-service bit. A value of 011xx nnn clears in-service bit nnn. A value of xxx01xxs selects pending (s=0) or in-service (s=1) for even-port reads. Other values have no effect.
- R9: The interrupt output is high exactly when the primary has a deliverable request, and it settles on the cycle after any state change. The wake output pulses for one cycle on each low-to-high change of the interrupt output.
- R10: The primary sits at ports 0020h/0021h, the secondary at 00A0h/00A1h, and the trigger-mode registers at 04D0h (primary) and 04D1h (secondary). Even ports read pending or in-service, odd ports read the mask, and any other address reads 0.
- R11: Only accesses with a size of 1 byte take effect. Writes of any other size change nothing, and reads of any other size return 0.
- R12: The vector is registered. It changes only in the cycle after an acknowledge strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Request lines, 0-7 primary, 8-15 secondary |
| ack_i | input | 1 | One-cycle interrupt acknowledge strobe |
| io_valid_i | input | 1 | I/O access strobe |
| io_wr_i | input | 1 | 1 = write, 0 = read |
| io_addr_i | input | 16 | I/O port address |
| io_size_i | input | 3 | Access size in bytes |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, valid the cycle after a read |
| int_o | output | 1 | Interrupt request to the processor |
| wake_o | output | 1 | One-cycle pulse on a rise of int_o |
| vector_o | output | 8 | Acknowledged vector |

## Verification
The bench uses the default parameters: bases 08h and 70h, the standard port set, and trigger masks F8h/DEh. With eight lines per controller, every line except the cascade line can be driven through a full request, acknowledge and retire cycle. All 21 pairs of primary lines can also be run, which covers both the priority order and the blocking of lower-priority requests. Fixed bases give every vector, including both spurious codes, a known value. Level-capable secondary bit 1 (line 9) makes it possible to withdraw a request after the cascade has latched it, and that is how the secondary spurious case is reached.

// File: rtl/cascade_ack_seq.sv
module cascade_ack_seq #(
  parameter logic [7:0]  PRI_BASE      = 8'h08,
  parameter logic [7:0]  SEC_BASE      = 8'h70,
  parameter logic [15:0] PRI_PORT      = 16'h0020,
  parameter logic [15:0] SEC_PORT      = 16'h00A0,
  parameter logic [15:0] TRIG_PORT     = 16'h04D0,
  parameter logic [7:0]  PRI_TRIG_MASK = 8'hF8,
  parameter logic [7:0]  SEC_TRIG_MASK = 8'hDE,
  parameter int          CASCADE_LINE  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_i,
  input  logic        ack_i,
  input  logic        io_valid_i,
  input  logic        io_wr_i,
  input  logic [15:0] io_addr_i,
  input  logic [2:0]  io_size_i,
  input  logic [7:0]  io_wdata_i,
  output logic [7:0]  io_rdata_o,
  output logic        int_o,
  output logic        wake_o,
  output logic [7:0]  vector_o
);
  localparam int N = 8;
  localparam int IW = $clog2(N);
  localparam logic [IW:0]  NONE    = (IW+1)'(N);
  localparam logic [IW:0]  CAS_IDX = (IW+1)'(CASCADE_LINE);
  localparam logic [N-1:0] CAS_BIT = N'(1) << CASCADE_LINE;
  localparam logic [7:0]   SPUR    = 8'(N - 1);

  function automatic logic [IW:0] pick(input logic [N-1:0] m);
    pick = NONE;
    for (int i = N - 1; i >= 0; i--)
      if (m[i]) pick = (IW+1)'(i);
  endfunction

  function automatic logic [N-1:0] onehot(input logic [IW:0] k);
    onehot = '0;
    if (!k[IW]) onehot[k[IW-1:0]] = 1'b1;
  endfunction

  logic [1:0]         wok;
  logic [1:0][IW:0]   wsel;
  logic [1:0][N-1:0]  ack_set;
  logic [1:0][N-1:0]  rd_c;
  logic               byte_ok, wr_ok, rd_ok, ack_pri, ack_cas, int_q;
  logic [7:0]         vec_nx;

  assign byte_ok = io_size_i == 3'd1;
  assign wr_ok   = io_valid_i & io_wr_i & byte_ok;
  assign rd_ok   = io_valid_i & ~io_wr_i;

  assign ack_pri    = ack_i & wok[0];
  assign ack_cas    = ack_pri & (wsel[0] == CAS_IDX);
  assign ack_set[0] = ack_pri ? onehot(wsel[0]) : '0;
  assign ack_set[1] = (ack_cas & wok[1]) ? onehot(wsel[1]) : '0;

  for (genvar c = 0; c < 2; c++) begin : g_ctl
    localparam logic [15:0]  CMD   = (c == 0) ? PRI_PORT : SEC_PORT;
    localparam logic [15:0]  TRG   = TRIG_PORT + 16'(c);
    localparam logic [N-1:0] TMASK = (c == 0) ? PRI_TRIG_MASK : SEC_TRIG_MASK;
    localparam logic [N-1:0] CAS   = (c == 0) ? CAS_BIT : '0;

    logic [N-1:0] irr, imr, isr, trig, last, line, eoi_clr, irr_nx, cas_set;
    logic [IW:0]  psel, isel;
    logic         rsel, hit_cmd, hit_dat, hit_trg, cmd_op;

    assign line = irq_i[c*N +: N] & ~CAS;
    assign psel = pick(irr & ~imr);
    assign isel = pick(isr);
    assign wsel[c] = psel;
    assign wok[c]  = psel < isel;

    assign hit_cmd = io_addr_i == CMD;
    assign hit_dat = io_addr_i == CMD + 16'd1;
    assign hit_trg = io_addr_i == TRG;
    assign cmd_op  = wr_ok & hit_cmd & (io_wdata_i[4:3] == 2'b00);

    assign eoi_clr = (cmd_op && io_wdata_i[7:5] == 3'b001) ? onehot(isel) :
                     (cmd_op && io_wdata_i[7:5] == 3'b011) ?
                       onehot((IW+1)'(io_wdata_i[IW-1:0])) : '0;

    assign cas_set = CAS & {N{wok[1]}} & ~ack_set[c];
    assign irr_nx  = (trig & line)
                   | (~trig & ((irr & ~ack_set[c]) | (line & ~last)))
                   | cas_set;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irr  <= '0;
        imr  <= '0;
        isr  <= '0;
        trig <= '0;
        last <= '0;
        rsel <= 1'b0;
      end else begin
        irr  <= irr_nx;
        last <= line;
        isr  <= (isr & ~eoi_clr) | ack_set[c];
        if (wr_ok && hit_dat) imr <= io_wdata_i;
        if (wr_ok && hit_trg) trig <= io_wdata_i & TMASK;
        if (wr_ok && hit_cmd && io_wdata_i[4:3] == 2'b01) rsel <= io_wdata_i[0];
      end
    end

    assign rd_c[c] = hit_cmd ? (rsel ? isr : irr) :
                     hit_dat ? imr :
                     hit_trg ? trig : '0;
  end

  always_comb begin
    if (!wok[0])
      vec_nx = PRI_BASE | SPUR;
    else if (ack_cas)
      vec_nx = wok[1] ? SEC_BASE + 8'(wsel[1]) : SEC_BASE | SPUR;
    else
      vec_nx = PRI_BASE + 8'(wsel[0]);
  end

  assign int_o  = wok[0];
  assign wake_o = int_o & ~int_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vector_o   <= '0;
      io_rdata_o <= '0;
      int_q      <= 1'b0;
    end else begin
      int_q <= int_o;
      if (ack_i) vector_o <= vec_nx;
      if (rd_ok) io_rdata_o <= byte_ok ? (rd_c[0] | rd_c[1]) : '0;
    end
  end
endmodule

// File: rtl/cascade_ack_seq_chk.sv
module cascade_ack_seq_chk #(
  parameter logic [7:0] PRI_BASE = 8'h08,
  parameter logic [7:0] SEC_BASE = 8'h70
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_i,
  input logic       io_valid_i,
  input logic       io_wr_i,
  input logic [2:0] io_size_i,
  input logic [7:0] io_rdata_o,
  input logic       int_o,
  input logic       wake_o,
  input logic [7:0] vector_o
);
  a_r9_wake_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (int_o && !$past(int_o)));

  a_r9_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  a_r5_spurious_primary: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o) |=> (vector_o == (PRI_BASE | 8'h07)));

  a_r12_vector_base: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> (vector_o[7:3] == PRI_BASE[7:3] || vector_o[7:3] == SEC_BASE[7:3]));

  a_r12_vector_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> $stable(vector_o));

  a_r11_wide_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid_i && !io_wr_i && io_size_i != 3'd1) |=> (io_rdata_o == 8'h00));
endmodule

bind cascade_ack_seq cascade_ack_seq_chk #(.PRI_BASE(PRI_BASE), .SEC_BASE(SEC_BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .io_valid_i(io_valid_i),
  .io_wr_i(io_wr_i), .io_size_i(io_size_i), .io_rdata_o(io_rdata_o),
  .int_o(int_o), .wake_o(wake_o), .vector_o(vector_o)
);

// File: tb/cascade_ack_seq_tb_top.sv
`timescale 1ns/1ps
module cascade_ack_seq_tb_top;
  localparam logic [7:0] PB = 8'h08;
  localparam logic [7:0] SB = 8'h70;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [15:0] irq;
  logic        ack, io_valid, io_wr;
  logic [15:0] io_addr;
  logic [2:0]  io_size;
  logic [7:0]  io_wdata, io_rdata, vector;
  logic        int_o, wake;

  cascade_ack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .ack_i(ack),
    .io_valid_i(io_valid), .io_wr_i(io_wr), .io_addr_i(io_addr),
    .io_size_i(io_size), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .int_o(int_o), .wake_o(wake), .vector_o(vector)
  );

  int nchk = 0, nerr = 0, wakes = 0;
  logic [7:0] v, d;

  always @(negedge clk) if (rst_n && wake) wakes++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] x, input logic [2:0] sz = 3'd1);
    io_valid = 1; io_wr = 1; io_addr = a; io_wdata = x; io_size = sz;
    @(negedge clk);
    io_valid = 0; io_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [2:0] sz, output logic [7:0] r);
    io_valid = 1; io_wr = 0; io_addr = a; io_size = sz;
    @(negedge clk);
    io_valid = 0;
    r = io_rdata;
  endtask

  task automatic do_ack(output logic [7:0] r);
    ack = 1;
    @(negedge clk);
    ack = 0;
    r = vector;
  endtask

  function automatic logic [7:0] vexp(input int l);
    return (l < 8) ? PB + 8'(l) : SB + 8'(l - 8);
  endfunction

  task automatic eoi_for(input int l);
    if (l >= 8) wr(16'h00A0, 8'h20);
    wr(16'h0020, 8'h20);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; irq = '0; ack = 0; io_valid = 0; io_wr = 0;
    io_addr = '0; io_size = 3'd1; io_wdata = '0;
    cyc(3); rst_n = 1; cyc(1);

    // R1 reset state
    chk("R1 int", int_o, 0);
    chk("R1 wake", wake, 0);
    chk("R1 vector", vector, 0);
    chk("R1 rdata", io_rdata, 0);
    rd(16'h0021, 1, d); chk("R1 mask", d, 0);
    rd(16'h0020, 1, d); chk("R1 pending", d, 0);
    rd(16'h04D1, 1, d); chk("R1 trigger", d, 0);

    // R2 R4 R9 sweep of every line
    wr(16'h0020, 8'h0B); wr(16'h00A0, 8'h0B);
    for (int l = 0; l < 16; l++) begin
      if (l == 2) continue;
      irq[l] = 1'b1; cyc(4);
      chk("R9 int raised", int_o, 1);
      do_ack(v); chk("R2/R4 vector", v, vexp(l));
      cyc(1); chk("R9 int after ack", int_o, 0);
      rd(16'h0020, 1, d); chk("R4 primary in-service", d, (l < 8) ? (32'd1 << l) : 32'h04);
      if (l >= 8) begin
        rd(16'h00A0, 1, d); chk("R4 secondary in-service", d, 32'd1 << (l - 8));
      end
      eoi_for(l); irq[l] = 1'b0; cyc(2);
      rd(16'h0020, 1, d); chk("R8 retired", d, 0);
    end
    chk("R9 wake count", wakes, 15);

    // R3 cascade line
    wr(16'h0020, 8'h0A); wr(16'h00A0, 8'h0A);
    irq[2] = 1; cyc(4);
    chk("R3 line2 ignored int", int_o, 0);
    rd(16'h0020, 1, d); chk("R3 line2 ignored pending", d, 0);
    irq[2] = 0;
    irq[12] = 1; cyc(4);
    rd(16'h0020, 1, d); chk("R3 cascade pending", d, 8'h04);
    rd(16'h00A0, 1, d); chk("R3 secondary pending", d, 8'h10);
    do_ack(v); chk("R4 vector 12", v, 8'h74);
    rd(16'h0020, 1, d); chk("R3 cascade cleared", d, 0);
    eoi_for(12); irq[12] = 0; cyc(2);

    // R2 all primary pairs
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        if (i == 2 || j == 2) continue;
        irq[i] = 1; irq[j] = 1; cyc(4);
        do_ack(v); chk("R2 pair high", v, vexp(i));
        cyc(2); chk("R2 lower blocked", int_o, 0);
        wr(16'h0020, 8'h20); cyc(1);
        chk("R2 lower released", int_o, 1);
        do_ack(v); chk("R2 pair low", v, vexp(j));
        wr(16'h0020, 8'h20); irq[i] = 0; irq[j] = 0; cyc(2);
      end
    end

    // R4 cascade priority against primary lines
    irq[9] = 1; irq[3] = 1; cyc(4);
    do_ack(v); chk("R4 cascade beats 3", v, 8'h71);
    eoi_for(9); cyc(1);
    do_ack(v); chk("R4 then 3", v, 8'h0B);
    eoi_for(3); irq[9] = 0; irq[3] = 0; cyc(2);
    irq[9] = 1; irq[1] = 1; cyc(4);
    do_ack(v); chk("R4 line1 beats cascade", v, 8'h09);
    wr(16'h0020, 8'h20); cyc(1);
    do_ack(v); chk("R4 then 9", v, 8'h71);
    eoi_for(9); irq[9] = 0; irq[1] = 0; cyc(2);

    // R2 masking
    wr(16'h0021, 8'h08); irq[3] = 1; cyc(4);
    chk("R2 masked int", int_o, 0);
    rd(16'h0021, 1, d); chk("R10 mask read", d, 8'h08);
    wr(16'h0021, 8'h00); cyc(2);
    chk("R2 unmasked int", int_o, 1);
    do_ack(v); chk("R2 unmasked vector", v, 8'h0B);
    eoi_for(3); irq[3] = 0; cyc(2);
    wr(16'h00A1, 8'h40); irq[14] = 1; cyc(4);
    chk("R2 secondary masked int", int_o, 0);
    rd(16'h0020, 1, d); chk("R3 no cascade when masked", d, 0);
    wr(16'h00A1, 8'h00); cyc(4);
    do_ack(v); chk("R2 secondary unmasked vector", v, 8'h76);
    eoi_for(14); irq[14] = 0; cyc(2);

    // R5 R12 primary spurious
    chk("R5 idle int", int_o, 0);
    do_ack(v); chk("R5 spurious vector", v, 8'h0F);
    wr(16'h0020, 8'h0B);
    rd(16'h0020, 1, d); chk("R5 in-service unchanged", d, 0);
    cyc(3); chk("R12 vector holds", vector, 8'h0F);

    // R8 nesting and specific retire
    irq[5] = 1; cyc(4);
    do_ack(v); chk("R8 first", v, 8'h0D);
    irq[3] = 1; cyc(4);
    chk("R2 higher preempts", int_o, 1);
    do_ack(v); chk("R8 nested", v, 8'h0B);
    rd(16'h0020, 1, d); chk("R8 two in service", d, 8'h28);
    wr(16'h0020, 8'h65);
    rd(16'h0020, 1, d); chk("R8 specific retire", d, 8'h08);
    wr(16'h0020, 8'h20);
    rd(16'h0020, 1, d); chk("R8 nonspecific retire", d, 8'h00);
    irq[5] = 0; irq[3] = 0; cyc(2);
    wr(16'h0020, 8'h0A);

    // R7 trigger-mode masks and behaviour
    wr(16'h04D0, 8'hFF); rd(16'h04D0, 1, d); chk("R7 primary trigger mask", d, 8'hF8);
    wr(16'h04D1, 8'hFF); rd(16'h04D1, 1, d); chk("R7 secondary trigger mask", d, 8'hDE);
    wr(16'h04D0, 8'h00); wr(16'h04D1, 8'h02);
    irq[9] = 1; cyc(4);
    do_ack(v); chk("R7 level vector", v, 8'h71);
    rd(16'h00A0, 1, d); chk("R7 level kept after ack", d, 8'h02);
    irq[9] = 0; cyc(2);
    rd(16'h00A0, 1, d); chk("R7 level follows line", d, 8'h00);
    eoi_for(9); cyc(2);
    chk("R7 idle after level", int_o, 0);
    irq[5] = 1; cyc(4);
    do_ack(v); chk("R7 edge vector", v, 8'h0D);
    rd(16'h0020, 1, d); chk("R7 edge cleared by ack", d, 8'h00);
    wr(16'h0020, 8'h20); cyc(2);
    chk("R7 held edge no retrigger", int_o, 0);
    irq[5] = 0; cyc(2);

    // R6 secondary spurious
    irq[9] = 1; cyc(4); irq[9] = 0; cyc(2);
    chk("R6 latched cascade int", int_o, 1);
    do_ack(v); chk("R6 secondary spurious", v, 8'h77);
    wr(16'h00A0, 8'h0B);
    rd(16'h00A0, 1, d); chk("R6 secondary in-service", d, 8'h00);
    wr(16'h0020, 8'h20); cyc(2);
    chk("R6 idle", int_o, 0);
    wr(16'h04D1, 8'h00); wr(16'h00A0, 8'h0A);

    // R11 access size, R10 unmapped
    wr(16'h0021, 8'h55, 3'd1);
    wr(16'h0021, 8'hFF, 3'd2);
    rd(16'h0021, 3'd1, d); chk("R11 wide write ignored", d, 8'h55);
    rd(16'h0021, 3'd2, d); chk("R11 wide read zero", d, 8'h00);
    rd(16'h0021, 3'd4, d); chk("R11 dword read zero", d, 8'h00);
    wr(16'h0021, 8'h00);
    rd(16'h0030, 3'd1, d); chk("R10 unmapped read", d, 8'h00);

    finish_run();
  end
endmodule